// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the purely combinational control unit for a five-stage, in-order pipeline. It looks at the register numbers, write enables and the load flag carried by the pipeline registers between stages. From these it decides three things for the current cycle. First, where each execute-stage operand comes from: the register file, the newest ALU result, or the write-back value. Second, whether a load-use dependency requires a one-cycle stall. Third, whether a taken branch or a jump resolved in decode requires the younger fetched instruction to be discarded.

The forwarding selects drive the two operand multiplexers in the execute stage. The stall output is active low. While it is low, the surrounding pipeline holds the program counter and the fetch/decode register and injects one bubble into decode. The flush output clears the fetch/decode register and zeroes the decode control outputs. There is no branch delay slot.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: An operand select is 2'b10 (execute/memory ALU result) when the execute/memory stage has its write enable set and its destination number equals that operand's source number, which is nonzero.
- R2: An operand select is 2'b01 (write-back result) when the memory/write-back stage has its write enable set and its destination equals the nonzero source number, and R1 does not apply to that operand.
- R3: In all other cases an operand select is 2'b00 (register-file value). A cleared write enable prevents a match, and the code 2'b11 is never produced.
- R4: When both later stages match the same source, the execute/memory result (2'b10) wins.
- R5: A source or destination of register 0 never causes forwarding or a stall.
- R6: Operand A is judged only on the decode/execute rs number and operand B only on the decode/execute rt number. The two selects are independent.
- R7: The stall output is 0 when the decode/execute instruction has memory-read set and its nonzero destination equals the fetch/decode rs or rt number, and flush is inactive.
- R8: The stall output is 1 when memory-read is clear, when the load destination is register 0, or when neither fetch/decode source matches.
- R9: Flush is 1 exactly when branch-taken or jump-select is 1.
- R10: Flush takes precedence over stall: while flush is 1 the stall output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs | input | REG_AW | rs number of the instruction in fetch/decode |
| ifid_rt | input | REG_AW | rt number of the instruction in fetch/decode |
| idex_rs | input | REG_AW | rs number held in decode/execute |
| idex_rt | input | REG_AW | rt number held in decode/execute |
| idex_rd | input | REG_AW | destination number held in decode/execute |
| idex_mem_rd | input | 1 | decode/execute instruction reads memory (load) |
| exmem_rd | input | REG_AW | destination number held in execute/memory |
| exmem_we | input | 1 | execute/memory register-write enable |
| memwb_rd | input | REG_AW | destination number held in memory/write-back |
| memwb_we | input | 1 | memory/write-back register-write enable |
| branch_taken | input | 1 | branch resolved taken in decode |
| jump_sel | input | 1 | jump selected in decode |
| fwd_a_sel | output | 2 | operand A source: 00 register file, 10 execute/memory, 01 write-back |
| fwd_b_sel | output | 2 | operand B source, same encoding |
| stall_n | output | 1 | load-use stall, active low |
| flush | output | 1 | discard the fetched instruction and clear decode controls |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a load-use stall together with a flush. The second pair is the execute/memory and write-back forwards both matching the same operand. Directed vectors set a load whose destination matches a fetch/decode source while branch-taken or jump-select is raised. These vectors expect flush high with the stall output held high. Other vectors give both later stages the same destination and expect 2'b10. Random vectors drawn from a small register range make these collisions frequent. Each output is compared against a model in the bench that restates the priority rules.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

  localparam int HZU_MAX_AW = 8;

  typedef enum logic [1:0] {
    FWD_RF = 2'b00,
    FWD_WB = 2'b01,
    FWD_EX = 2'b10
  } fwd_sel_e;

  // A producing stage supplies a source when it writes, its destination is
  // a real register, and the numbers agree.
  function automatic logic dest_matches(logic [HZU_MAX_AW-1:0] dest,
                                        logic                  we,
                                        logic [HZU_MAX_AW-1:0] src);
    return we && (dest != '0) && (dest == src);
  endfunction

  // Newer result first, then the write-back result, else the register file.
  function automatic fwd_sel_e pick_source(logic ex_hit, logic wb_hit);
    if (ex_hit)      return FWD_EX;
    else if (wb_hit) return FWD_WB;
    else             return FWD_RF;
  endfunction

endpackage

// File: rtl/hzu_fwd_sel.sv
module hzu_fwd_sel
  import hzu_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  output fwd_sel_e          sel,
  output logic              ex_hit,
  output logic              wb_hit
);

  always_comb begin
    ex_hit = dest_matches(HZU_MAX_AW'(ex_rd), ex_we, HZU_MAX_AW'(src));
    wb_hit = dest_matches(HZU_MAX_AW'(wb_rd), wb_we, HZU_MAX_AW'(src));
    sel    = pick_source(ex_hit, wb_hit);

    if (src == '0) begin
      assert_zero_src_R5: assert (sel == FWD_RF)
        else $error("register 0 source forwarded");
    end
    if (ex_we && (ex_rd == src) && (src != '0)) begin
      assert_ex_first_R4: assert (sel == FWD_EX)
        else $error("newer result not chosen");
    end
    if (!ex_we && !wb_we) begin
      assert_no_we_R3: assert (sel == FWD_RF)
        else $error("forward without a write enable");
    end
  end

endmodule

// File: rtl/hzu_load_use.sv
module hzu_load_use
  import hzu_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ld_rd,
  input  logic              ld_mem_rd,
  input  logic [REG_AW-1:0] use_rs,
  input  logic [REG_AW-1:0] use_rt,
  output logic              rs_dep,
  output logic              rt_dep,
  output logic              lu_hit
);

  always_comb begin
    rs_dep = dest_matches(HZU_MAX_AW'(ld_rd), ld_mem_rd, HZU_MAX_AW'(use_rs));
    rt_dep = dest_matches(HZU_MAX_AW'(ld_rd), ld_mem_rd, HZU_MAX_AW'(use_rt));
    lu_hit = rs_dep | rt_dep;

    if (ld_rd == '0 || !ld_mem_rd) begin
      assert_lu_quiet_R8: assert (!lu_hit)
        else $error("load-use raised without a real load destination");
    end
  end

endmodule

// File: rtl/hzu_ctl_merge.sv
module hzu_ctl_merge (
  input  logic lu_hit,
  input  logic branch_taken,
  input  logic jump_sel,
  output logic redirect,
  output logic stall_n,
  output logic flush
);

  always_comb begin
    redirect = branch_taken | jump_sel;
    flush    = redirect;
    // A redirect discards the dependent instruction, so no stall is needed.
    stall_n  = redirect | ~lu_hit;

    if (flush) begin
      assert_flush_wins_R10: assert (stall_n)
        else $error("stall asserted during flush");
    end
    if (lu_hit && !branch_taken && !jump_sel) begin
      assert_stall_on_lu_R7: assert (!stall_n)
        else $error("load-use not stalled");
    end
    if (!branch_taken && !jump_sel) begin
      assert_flush_src_R9: assert (!flush)
        else $error("flush without a redirect");
    end
  end

endmodule

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl
  import hzu_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ifid_rs,
  input  logic [REG_AW-1:0] ifid_rt,
  input  logic [REG_AW-1:0] idex_rs,
  input  logic [REG_AW-1:0] idex_rt,
  input  logic [REG_AW-1:0] idex_rd,
  input  logic              idex_mem_rd,
  input  logic [REG_AW-1:0] exmem_rd,
  input  logic              exmem_we,
  input  logic [REG_AW-1:0] memwb_rd,
  input  logic              memwb_we,
  input  logic              branch_taken,
  input  logic              jump_sel,
  output logic [1:0]        fwd_a_sel,
  output logic [1:0]        fwd_b_sel,
  output logic              stall_n,
  output logic              flush
);

  localparam int N_OPND = 2;

  logic [REG_AW-1:0] opnd_src [N_OPND];
  fwd_sel_e          opnd_sel [N_OPND];
  logic [N_OPND-1:0] opnd_ex_hit;
  logic [N_OPND-1:0] opnd_wb_hit;
  logic              rs_dep, rt_dep, lu_hit, redirect;

  assign opnd_src[0] = idex_rs;
  assign opnd_src[1] = idex_rt;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    hzu_fwd_sel #(.REG_AW(REG_AW)) u_fwd (
      .src    (opnd_src[g]),
      .ex_rd  (exmem_rd),
      .ex_we  (exmem_we),
      .wb_rd  (memwb_rd),
      .wb_we  (memwb_we),
      .sel    (opnd_sel[g]),
      .ex_hit (opnd_ex_hit[g]),
      .wb_hit (opnd_wb_hit[g])
    );
  end

  hzu_load_use #(.REG_AW(REG_AW)) u_lu (
    .ld_rd     (idex_rd),
    .ld_mem_rd (idex_mem_rd),
    .use_rs    (ifid_rs),
    .use_rt    (ifid_rt),
    .rs_dep    (rs_dep),
    .rt_dep    (rt_dep),
    .lu_hit    (lu_hit)
  );

  hzu_ctl_merge u_merge (
    .lu_hit       (lu_hit),
    .branch_taken (branch_taken),
    .jump_sel     (jump_sel),
    .redirect     (redirect),
    .stall_n      (stall_n),
    .flush        (flush)
  );

  always_comb begin
    fwd_a_sel = opnd_sel[0];
    fwd_b_sel = opnd_sel[1];

    if (opnd_ex_hit[0] && opnd_wb_hit[0]) begin
      assert_both_hit_R4: assert (fwd_a_sel == 2'b10)
        else $error("operand A priority wrong");
    end
    if (rs_dep || rt_dep) begin
      assert_dep_load_R7: assert (idex_mem_rd && idex_rd != '0)
        else $error("dependency without a load");
    end
    if (redirect) begin
      assert_redirect_R9: assert (flush && stall_n)
        else $error("redirect not flushed");
    end
  end

endmodule

// File: tb/hazard_fwd_ctrl_tb.sv
module hazard_fwd_ctrl_tb;

  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, idex_rd;
  logic [AW-1:0] exmem_rd, memwb_rd;
  logic idex_mem_rd, exmem_we, memwb_we, branch_taken, jump_sel;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic stall_n, flush;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  hazard_fwd_ctrl #(.REG_AW(AW)) u_dut (
    .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
    .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_rd(idex_rd),
    .idex_mem_rd(idex_mem_rd),
    .exmem_rd(exmem_rd), .exmem_we(exmem_we),
    .memwb_rd(memwb_rd), .memwb_we(memwb_we),
    .branch_taken(branch_taken), .jump_sel(jump_sel),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
    .stall_n(stall_n), .flush(flush)
  );

  function automatic logic [1:0] model_fwd(logic [AW-1:0] s);
    if (s == 0) return 2'b00;
    if (exmem_we && exmem_rd == s) return 2'b10;
    if (memwb_we && memwb_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic model_flush();
    return branch_taken || jump_sel;
  endfunction

  function automatic logic model_stall_n();
    logic dep;
    dep = idex_mem_rd && idex_rd != 0 &&
          (idex_rd == ifid_rs || idex_rd == ifid_rt);
    if (model_flush()) return 1'b1;
    return !dep;
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(logic [AW-1:0] frs, logic [AW-1:0] frt,
                       logic [AW-1:0] ers, logic [AW-1:0] ert,
                       logic [AW-1:0] erd, logic mrd,
                       logic [AW-1:0] xrd, logic xwe,
                       logic [AW-1:0] wrd, logic wwe,
                       logic bt, logic js);
    @(negedge clk);
    ifid_rs = frs; ifid_rt = frt; idex_rs = ers; idex_rt = ert;
    idex_rd = erd; idex_mem_rd = mrd; exmem_rd = xrd; exmem_we = xwe;
    memwb_rd = wrd; memwb_we = wwe; branch_taken = bt; jump_sel = js;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(string tag);
    chk({tag, " fwd_a R1 R2 R3 R4 R5 R6"}, fwd_a_sel, model_fwd(idex_rs));
    chk({tag, " fwd_b R1 R2 R3 R4 R5 R6"}, fwd_b_sel, model_fwd(idex_rt));
    chk({tag, " stall_n R7 R8 R10"}, {1'b0, stall_n}, {1'b0, model_stall_n()});
    chk({tag, " flush R9"}, {1'b0, flush}, {1'b0, model_flush()});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    ifid_rs = '0; ifid_rt = '0; idex_rs = '0; idex_rt = '0; idex_rd = '0;
    idex_mem_rd = 0; exmem_rd = '0; exmem_we = 0; memwb_rd = '0; memwb_we = 0;
    branch_taken = 0; jump_sel = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // idle state
    chk("idle fwd_a R3", fwd_a_sel, 2'b00);
    chk("idle fwd_b R3", fwd_b_sel, 2'b00);
    chk("idle stall_n R8", {1'b0, stall_n}, 2'b01);
    chk("idle flush R9", {1'b0, flush}, 2'b00);

    // R1: execute/memory forward to A
    drive(0,0, 3,4, 0,0, 3,1, 0,0, 0,0);
    chk("R1 ex to A", fwd_a_sel, 2'b10);
    chk("R6 B untouched", fwd_b_sel, 2'b00);
    // R2: write-back forward to B
    drive(0,0, 3,4, 0,0, 0,0, 4,1, 0,0);
    chk("R2 wb to B", fwd_b_sel, 2'b01);
    chk("R6 A untouched", fwd_a_sel, 2'b00);
    // R3: write enables clear
    drive(0,0, 3,4, 0,0, 3,0, 4,0, 0,0);
    chk("R3 no we A", fwd_a_sel, 2'b00);
    chk("R3 no we B", fwd_b_sel, 2'b00);
    // R4: both stages match
    drive(0,0, 7,7, 0,0, 7,1, 7,1, 0,0);
    chk("R4 priority A", fwd_a_sel, 2'b10);
    chk("R4 priority B", fwd_b_sel, 2'b10);
    // R5: register 0
    drive(0,0, 0,0, 0,1, 0,1, 0,1, 0,0);
    chk("R5 zero A", fwd_a_sel, 2'b00);
    chk("R5 zero B", fwd_b_sel, 2'b00);
    chk("R5 zero load", {1'b0, stall_n}, 2'b01);
    // R7: load-use on rs and on rt
    drive(9,2, 0,0, 9,1, 0,0, 0,0, 0,0);
    chk("R7 rs dep", {1'b0, stall_n}, 2'b00);
    drive(2,9, 0,0, 9,1, 0,0, 0,0, 0,0);
    chk("R7 rt dep", {1'b0, stall_n}, 2'b00);
    // R8: not a load, or no match
    drive(9,9, 0,0, 9,0, 0,0, 0,0, 0,0);
    chk("R8 no memrd", {1'b0, stall_n}, 2'b01);
    drive(1,2, 0,0, 9,1, 0,0, 0,0, 0,0);
    chk("R8 no match", {1'b0, stall_n}, 2'b01);
    // R9 and R10: flush with concurrent load-use
    drive(9,2, 0,0, 9,1, 0,0, 0,0, 1,0);
    chk("R9 branch flush", {1'b0, flush}, 2'b01);
    chk("R10 branch over stall", {1'b0, stall_n}, 2'b01);
    drive(2,9, 0,0, 9,1, 0,0, 0,0, 0,1);
    chk("R9 jump flush", {1'b0, flush}, 2'b01);
    chk("R10 jump over stall", {1'b0, stall_n}, 2'b01);

    // random: small register range makes collisions frequent
    for (int i = 0; i < 3000; i++) begin
      drive(AW'($urandom_range(0,3)), AW'($urandom_range(0,3)),
            AW'($urandom_range(0,3)), AW'($urandom_range(0,3)),
            AW'($urandom_range(0,3)), 1'($urandom_range(0,1)),
            AW'($urandom_range(0,3)), 1'($urandom_range(0,1)),
            AW'($urandom_range(0,3)), 1'($urandom_range(0,1)),
            1'($urandom_range(0,3) == 0), 1'($urandom_range(0,3) == 0));
      check_all("rand");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule